// File: doc/BRIEF.md
# Double-Rate Prefetch Burst Data Path

This block sits between a memory core that moves one 2n-bit word per clock and a pin interface that carries n-bit beats on both halves of the clock. Each beat is modelled as an ordinary single-rate lane: a "rise" lane for the first half of the clock and a "fall" lane for the second. On a read burst the block fetches one core word per clock and, one clock later, splits it into the two lanes. On a write burst it collects the two lanes into one word. It merges that word with the word already in the core under per-byte masks, then writes it back one clock later.

A burst begins with a read or write request and a starting column. Columns are counted in beats and a core word holds two of them, so the word column is the start column shifted right by one. The burst length comes from a 2-bit select: 2, 4 or 8 beats wrap inside an aligned block of word columns, and the full-page setting runs to the top of a 256-column page. A stop input ends any burst early. The block drives a strobe-enable window that covers only the data beats. It also drives a flag that tells the physical layer whether to centre the strobe in the data eye (writes) or align it with the data edges (reads).

Top module: `ddr_prefetch_path`

## Requirements
- R1: After reset, strobe_en, strobe_center, core_rd_en and core_wr_en are 0, and rd_rise_data and rd_fall_data are 0.
- R2: A core word fetched while core_rd_en is high appears on the pins in the next clock, with bits [n-1:0] on rd_rise_data (first beat) and bits [2n-1:n] on rd_fall_data.
- R3: bl_sel values 0, 1 and 2 give bursts of 1, 2 and 4 core words (2, 4 or 8 beats). The word column starts at start_col>>1 and steps by one with wrap-around inside the aligned block of that many words.
- R4: bl_sel = 3 (full page) steps the word column by one each clock, with no wrap, and ends after word column 127 (columns 254/255).
- R5: burst_stop sampled high in an active burst clock makes that clock's word the last one of the burst.
- R6: In each write-burst clock, wr_rise_data and wr_fall_data form the lower and upper halves of one word. That word is written one clock later with core_wr_en high, at the word column of its beats.
- R7: Mask bit b of wr_rise_mask covers bits [8b+7:8b] of the rise beat, and bit b of wr_fall_mask covers the same byte of the fall beat. A set bit keeps that byte's previous core contents, taken from core_rd_data.
- R8: strobe_en is high in exactly the clocks that carry read beats on the rd lanes or accept write beats, and it is low in the clock after the last beat.
- R9: strobe_center is high during write beats and low during read beats.
- R10: A request that arrives while a burst is active is ignored. If rd_req and wr_req arrive together while the block is idle, the read is performed.
- R11: rd_rise_data and rd_fall_data are 0 in every clock that carries no read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bl_sel | input | 2 | Burst length select: 0=2, 1=4, 2=8 beats, 3=full page |
| rd_req | input | 1 | Start a read burst (sampled when idle) |
| wr_req | input | 1 | Start a write burst (sampled when idle) |
| start_col | input | COL_W | Starting beat column of the burst |
| burst_stop | input | 1 | Make the current burst clock the last |
| core_addr | output | COL_W-1 | Core word column for a fetch or a write |
| core_rd_en | output | 1 | Core word fetch for a read burst |
| core_rd_data | input | 2*BEAT_W | Core word at core_addr (combinational) |
| core_wr_en | output | 1 | Write the merged word at core_addr |
| core_wr_data | output | 2*BEAT_W | Merged write word |
| wr_rise_data | input | BEAT_W | First write beat of the clock |
| wr_fall_data | input | BEAT_W | Second write beat of the clock |
| wr_rise_mask | input | BEAT_W/8 | Per-byte mask of the first beat |
| wr_fall_mask | input | BEAT_W/8 | Per-byte mask of the second beat |
| rd_rise_data | output | BEAT_W | First read beat of the clock |
| rd_fall_data | output | BEAT_W | Second read beat of the clock |
| strobe_en | output | 1 | Strobe window, high during data beats |
| strobe_center | output | 1 | 1: centre strobe in the eye (write); 0: edge-aligned (read) |

## Verification
The case hardest to reach from the ports is a full-page burst that ends at the top of the page. The column counter has to reach word 127 without wrapping, which a short burst never shows. The bench starts full-page bursts near the top of the page, so that the end arrives within a few clocks, and it starts one at column 0 and cuts it with burst_stop to cover the early exit. A further hard case is a request that arrives during a burst. The bench raises wr_req in the middle of an 8-beat read, then checks that the read keeps its length and that the core contents are unchanged.

// File: rtl/ddr_pfx_pkg.sv
package ddr_pfx_pkg;

    typedef enum logic [1:0] {
        BL_2    = 2'd0,
        BL_4    = 2'd1,
        BL_8    = 2'd2,
        BL_PAGE = 2'd3
    } burst_len_e;

    // core words in a fixed-length burst, minus one
    function automatic logic [1:0] words_m1(input burst_len_e bl);
        case (bl)
            BL_2:    words_m1 = 2'd0;
            BL_4:    words_m1 = 2'd1;
            BL_8:    words_m1 = 2'd3;
            default: words_m1 = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr_burst_ctl.sv
module ddr_burst_ctl
    import ddr_pfx_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         bl_sel,
    input  logic               rd_req,
    input  logic               wr_req,
    input  logic [COL_W-1:0]   start_col,
    input  logic               burst_stop,
    output logic               active,
    output logic               is_wr,
    output logic [COL_W-2:0]   word_col
);
    localparam int WC_W = COL_W - 1;

    typedef struct packed {
        logic            active;
        logic            is_wr;
        burst_len_e      bl;
        logic [WC_W-1:0] wcol;
        logic [1:0]      left;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic            last_beat;
    logic [WC_W-1:0] wrap_mask;
    logic [WC_W-1:0] wcol_inc;

    always_comb begin
        ctl_d     = ctl_q;
        wrap_mask = WC_W'(words_m1(ctl_q.bl));
        wcol_inc  = ctl_q.wcol + WC_W'(1);
        last_beat = 1'b0;
        if (!ctl_q.active) begin
            if (rd_req || wr_req) begin
                ctl_d.active = 1'b1;
                ctl_d.is_wr  = !rd_req;
                ctl_d.bl     = burst_len_e'(bl_sel);
                ctl_d.wcol   = WC_W'(start_col >> 1);
                ctl_d.left   = words_m1(burst_len_e'(bl_sel));
            end
        end else begin
            if (ctl_q.bl == BL_PAGE) begin
                last_beat = &ctl_q.wcol;
            end else begin
                last_beat = (ctl_q.left == 2'd0);
            end
            if (last_beat || burst_stop) begin
                ctl_d.active = 1'b0;
            end else begin
                ctl_d.left = ctl_q.left - 2'd1;
                if (ctl_q.bl == BL_PAGE) begin
                    ctl_d.wcol = wcol_inc;
                end else begin
                    ctl_d.wcol = (ctl_q.wcol & ~wrap_mask) | (wcol_inc & wrap_mask);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{active: 1'b0, is_wr: 1'b0, bl: BL_2, wcol: '0, left: 2'd0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active   = ctl_q.active;
    assign is_wr    = ctl_q.is_wr;
    assign word_col = ctl_q.wcol;

endmodule

// File: rtl/ddr_rd_split.sv
module ddr_rd_split #(
    parameter int BEAT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch,
    input  logic [2*BEAT_W-1:0] core_word,
    output logic                beat_valid,
    output logic [BEAT_W-1:0]   rise_beat,
    output logic [BEAT_W-1:0]   fall_beat
);
    typedef struct packed {
        logic              valid;
        logic [BEAT_W-1:0] rise;
        logic [BEAT_W-1:0] fall;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = fetch;
        rd_d.rise  = fetch ? core_word[BEAT_W-1:0]        : '0;
        rd_d.fall  = fetch ? core_word[2*BEAT_W-1:BEAT_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign beat_valid = rd_q.valid;
    assign rise_beat  = rd_q.rise;
    assign fall_beat  = rd_q.fall;

endmodule

// File: rtl/ddr_wr_merge.sv
module ddr_wr_merge #(
    parameter int BEAT_W = 32,
    parameter int WC_W   = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [WC_W-1:0]       wcol,
    input  logic [BEAT_W-1:0]     rise_beat,
    input  logic [BEAT_W-1:0]     fall_beat,
    input  logic [BEAT_W/8-1:0]   rise_mask,
    input  logic [BEAT_W/8-1:0]   fall_mask,
    input  logic [2*BEAT_W-1:0]   old_word,
    output logic                  wr_en,
    output logic [WC_W-1:0]       wr_addr,
    output logic [2*BEAT_W-1:0]   wr_word
);
    localparam int BYTES = 2 * BEAT_W / 8;

    typedef struct packed {
        logic                valid;
        logic [WC_W-1:0]     addr;
        logic [2*BEAT_W-1:0] data;
        logic [BYTES-1:0]    mask;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d       = wr_q;
        wr_d.valid = take;
        if (take) begin
            wr_d.addr = wcol;
            wr_d.data = {fall_beat, rise_beat};
            wr_d.mask = {fall_mask, rise_mask};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign wr_word[8*b +: 8] = wr_q.mask[b] ? old_word[8*b +: 8] : wr_q.data[8*b +: 8];
    end

    assign wr_en   = wr_q.valid;
    assign wr_addr = wr_q.addr;

endmodule

// File: rtl/ddr_prefetch_path.sv
module ddr_prefetch_path #(
    parameter int BEAT_W = 32,
    parameter int COL_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            bl_sel,
    input  logic                  rd_req,
    input  logic                  wr_req,
    input  logic [COL_W-1:0]      start_col,
    input  logic                  burst_stop,
    output logic [COL_W-2:0]      core_addr,
    output logic                  core_rd_en,
    input  logic [2*BEAT_W-1:0]   core_rd_data,
    output logic                  core_wr_en,
    output logic [2*BEAT_W-1:0]   core_wr_data,
    input  logic [BEAT_W-1:0]     wr_rise_data,
    input  logic [BEAT_W-1:0]     wr_fall_data,
    input  logic [BEAT_W/8-1:0]   wr_rise_mask,
    input  logic [BEAT_W/8-1:0]   wr_fall_mask,
    output logic [BEAT_W-1:0]     rd_rise_data,
    output logic [BEAT_W-1:0]     rd_fall_data,
    output logic                  strobe_en,
    output logic                  strobe_center
);
    localparam int WC_W = COL_W - 1;

    logic            burst_active;
    logic            burst_wr;
    logic [WC_W-1:0] burst_wcol;
    logic            rd_beat_valid;
    logic            wr_take;
    logic [WC_W-1:0] merge_addr;

    ddr_burst_ctl #(.COL_W(COL_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bl_sel     (bl_sel),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .start_col  (start_col),
        .burst_stop (burst_stop),
        .active     (burst_active),
        .is_wr      (burst_wr),
        .word_col   (burst_wcol)
    );

    assign core_rd_en = burst_active && !burst_wr;
    assign wr_take    = burst_active && burst_wr;

    ddr_rd_split #(.BEAT_W(BEAT_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch      (core_rd_en),
        .core_word  (core_rd_data),
        .beat_valid (rd_beat_valid),
        .rise_beat  (rd_rise_data),
        .fall_beat  (rd_fall_data)
    );

    ddr_wr_merge #(.BEAT_W(BEAT_W), .WC_W(WC_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (wr_take),
        .wcol      (burst_wcol),
        .rise_beat (wr_rise_data),
        .fall_beat (wr_fall_data),
        .rise_mask (wr_rise_mask),
        .fall_mask (wr_fall_mask),
        .old_word  (core_rd_data),
        .wr_en     (core_wr_en),
        .wr_addr   (merge_addr),
        .wr_word   (core_wr_data)
    );

    assign core_addr     = core_wr_en ? merge_addr : burst_wcol;
    assign strobe_en     = rd_beat_valid || wr_take;
    assign strobe_center = wr_take;

endmodule

// File: rtl/ddr_prefetch_path_chk.sv
module ddr_prefetch_path_chk #(
    parameter int BEAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_rd_en,
    input logic              core_wr_en,
    input logic              strobe_en,
    input logic              strobe_center,
    input logic [BEAT_W-1:0] rd_rise_data,
    input logic [BEAT_W-1:0] rd_fall_data
);
    // R9
    center_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_center |-> strobe_en);

    // R6
    wr_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_en |-> $past(strobe_center));

    // R10
    one_core_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rd_en && core_wr_en));

    // R8
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd_en |=> (strobe_en && !strobe_center));

    // R11
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_en |-> (rd_rise_data == '0 && rd_fall_data == '0));
endmodule

bind ddr_prefetch_path ddr_prefetch_path_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_rd_en    (core_rd_en),
    .core_wr_en    (core_wr_en),
    .strobe_en     (strobe_en),
    .strobe_center (strobe_center),
    .rd_rise_data  (rd_rise_data),
    .rd_fall_data  (rd_fall_data)
);

// File: tb/ddr_prefetch_path_tb.sv
module ddr_prefetch_path_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 32;
    localparam int CW = 8;
    localparam int NW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bl_sel = '0;
    logic          rd_req = 1'b0, wr_req = 1'b0, burst_stop = 1'b0;
    logic [CW-1:0] start_col = '0;
    logic [CW-2:0] core_addr;
    logic          core_rd_en, core_wr_en;
    logic [2*BW-1:0] core_rd_data, core_wr_data;
    logic [BW-1:0] wr_rise_data = '0, wr_fall_data = '0;
    logic [BW/8-1:0] wr_rise_mask = '0, wr_fall_mask = '0;
    logic [BW-1:0] rd_rise_data, rd_fall_data;
    logic          strobe_en, strobe_center;

    logic [2*BW-1:0] mem [NW];
    logic [2*BW-1:0] shadow [NW];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_prefetch_path #(.BEAT_W(BW), .COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bl_sel(bl_sel), .rd_req(rd_req), .wr_req(wr_req),
        .start_col(start_col), .burst_stop(burst_stop), .core_addr(core_addr),
        .core_rd_en(core_rd_en), .core_rd_data(core_rd_data), .core_wr_en(core_wr_en),
        .core_wr_data(core_wr_data), .wr_rise_data(wr_rise_data), .wr_fall_data(wr_fall_data),
        .wr_rise_mask(wr_rise_mask), .wr_fall_mask(wr_fall_mask), .rd_rise_data(rd_rise_data),
        .rd_fall_data(rd_fall_data), .strobe_en(strobe_en), .strobe_center(strobe_center)
    );

    function automatic logic [2*BW-1:0] init_word(input int i);
        return {32'hC0DE0000 + 32'(i), 32'h5A000000 ^ (32'(i) * 32'h00010203)};
    endfunction

    // core model
    assign core_rd_data = mem[core_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
        end else if (core_wr_en) begin
            mem[core_addr] <= core_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [2*BW-1:0] act,
                       input logic [2*BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int wcol_of(input int bl, input int sw, input int i);
        int m;
        if (bl == 3) return sw + i;
        m = (1 << bl) - 1;
        return (sw & ~m) | ((sw + i) & m);
    endfunction

    function automatic int nwords(input int bl, input int sw, input int term);
        int n;
        n = (bl == 3) ? (NW - sw) : (1 << bl);
        if (term >= 0 && term + 1 < n) n = term + 1;
        return n;
    endfunction

    task automatic mem_matches(input string req);
        int bad_i;
        bad_i = -1;
        for (int i = 0; i < NW; i++) if (mem[i] !== shadow[i] && bad_i < 0) bad_i = i;
        chk(bad_i < 0, req, (bad_i < 0) ? 64'd0 : mem[bad_i], (bad_i < 0) ? 64'd0 : shadow[bad_i]);
    endtask

    // read burst; term = stop at word term, inject = wr_req in fetch clock 1, both = wr_req with rd_req
    task automatic do_read(input int bl, input int scol, input int term, input bit inject,
                           input bit both, input string req);
        int sw, n, w;
        sw = scol >> 1;
        n  = nwords(bl, sw, term);
        @(negedge clk);
        bl_sel = 2'(bl); start_col = CW'(scol); rd_req = 1'b1; wr_req = both;
        @(posedge clk); @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0; burst_stop = (term == 0);
        // R8: no read beat yet in the fetch clock
        chk(!strobe_en, "R8 no strobe during first fetch", 64'(strobe_en), 64'd0);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            burst_stop = (term == k + 1);
            wr_req = inject && (k == 0);
            w = wcol_of(bl, sw, k);
            // R2 R3 R4 R9: beat order and address sequence
            chk(strobe_en && !strobe_center && rd_rise_data === shadow[w][BW-1:0]
                && rd_fall_data === shadow[w][2*BW-1:BW], req,
                {rd_fall_data, rd_rise_data}, shadow[w]);
        end
        burst_stop = 1'b0; wr_req = 1'b0;
        @(posedge clk); @(negedge clk);
        // R8 R11: window closes one clock after the last beat
        chk(!strobe_en && rd_rise_data == '0 && rd_fall_data == '0, "R8 R11 window closed",
            {rd_fall_data, rd_rise_data}, 64'd0);
    endtask

    task automatic do_write(input int bl, input int scol, input string req);
        int sw, n, w;
        logic [BW-1:0] rb, fb;
        logic [3:0] rm, fm;
        sw = scol >> 1;
        n  = nwords(bl, sw, -1);
        @(negedge clk);
        bl_sel = 2'(bl); start_col = CW'(scol); wr_req = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            w  = wcol_of(bl, sw, i);
            rb = 32'h11223344 ^ (32'(i) * 32'h01010101) ^ 32'(scol << 8);
            fb = 32'h99AABBCC ^ (32'(i) * 32'h10101010);
            rm = 4'(i * 3);
            fm = 4'(~i);
            wr_rise_data = rb; wr_fall_data = fb; wr_rise_mask = rm; wr_fall_mask = fm;
            // R8 R9: write beats open a centred strobe window
            chk(strobe_en && strobe_center, "R8 R9 write window", {62'd0, strobe_en, strobe_center}, 64'd3);
            for (int b = 0; b < 4; b++) begin
                if (!rm[b]) shadow[w][8*b +: 8] = rb[8*b +: 8];
                if (!fm[b]) shadow[w][BW + 8*b +: 8] = fb[8*b +: 8];
            end
            @(posedge clk); @(negedge clk);
        end
        wr_rise_data = '0; wr_fall_data = '0; wr_rise_mask = '0; wr_fall_mask = '0;
        chk(!strobe_en && !strobe_center, "R8 write window closed", 64'(strobe_en), 64'd0);
        @(posedge clk); @(negedge clk);
        // R6 R7: merged words land in the core
        mem_matches(req);
    endtask

    task automatic t_reset();
        // R1
        chk(!strobe_en && !strobe_center && !core_rd_en && !core_wr_en
            && rd_rise_data == '0 && rd_fall_data == '0, "R1 reset state",
            {rd_fall_data, rd_rise_data}, 64'd0);
    endtask

    task automatic t_read_lengths();
        do_read(0, 6, -1, 0, 0, "R3 read BL2");
        do_read(1, 6, -1, 0, 0, "R3 read BL4 wrap");
        do_read(2, 10, -1, 0, 0, "R3 read BL8 wrap");
    endtask

    task automatic t_writes();
        do_write(2, 4, "R6 R7 write BL8 masked");
        do_write(1, 22, "R6 R7 write BL4 masked");
        do_read(2, 4, -1, 0, 0, "R2 readback BL8");
        do_write(3, 240, "R4 R7 full page write");
    endtask

    task automatic t_full_page();
        do_read(3, 250, -1, 0, 0, "R4 full page to top");
        do_read(3, 0, 5, 0, 0, "R5 full page stopped");
        do_read(2, 8, 1, 0, 0, "R5 BL8 stopped");
    endtask

    task automatic t_requests();
        do_read(2, 16, -1, 1, 0, "R10 request ignored while busy");
        mem_matches("R10 no write from ignored request");
        do_read(0, 30, -1, 0, 1, "R10 read wins");
        mem_matches("R10 no write when both requested");
    endtask

    initial begin
        for (int i = 0; i < NW; i++) shadow[i] = init_word(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_lengths();
        t_writes();
        t_full_page();
        t_requests();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule